// File: doc/BRIEF.md
# Mains-Null Decimating Boxcar Averager

This block low-pass filters a stream of converter samples taken at a high, fixed rate. It also reduces the stream to a slow stream of clean DC readings for a control loop. Each accepted sample enters a circular history whose depth equals the averaging window. A running total adds the newcomer and drops the sample that leaves the window. The window is sized to a whole number of mains cycles, for example 20 ms at 50 Hz or 16.7 ms at 60 Hz. As a result, the frequency response has zeros at the mains frequency and at every harmonic of it.

The block issues an averaged result once every `DEC` accepted samples. It does so only after a full window has been collected since reset. The default parameters assume 3 kS/s input with a 60-sample (20 ms) window and decimation by 100, which gives 30 results per second. The group delay of the average is half the window, 10 ms with the defaults. A power-of-two window divides by shifting. Any other length multiplies by a fixed-point reciprocal that is exact for every reachable total.

Top module: `mains_boxcar`

## Requirements
- R1: While reset is held and on the first cycle after it, `avg_valid` is 0 and `avg_out` is 0.
- R2: `avg_valid` stays 0 until at least `WIN` samples have been accepted since reset.
- R3: The running total cannot overflow. A full window of all-ones samples gives an all-ones result.
- R4: A constant input value gives exactly that value at `avg_out` once the window holds only that value.
- R5: `avg_valid` is a one-cycle pulse. It is high in the cycle after the accepted sample whose count since reset is a multiple of `DEC`, provided at least `WIN` samples have been accepted. Successive pulses are exactly `DEC` accepted samples apart.
- R6: When `avg_valid` is high, `avg_out` equals floor(sum of the last `WIN` accepted samples / `WIN`), the sample that triggered the pulse included.
- R7: Cycles with `smp_valid` = 0 are ignored whatever `smp_data` holds. They change neither the window contents nor the sample count.
- R8: `avg_out` holds its value between pulses and changes only on the cycle in which `avg_valid` is high.
- R9: A power-of-two `WIN` (shift division) and any other `WIN` (reciprocal multiply) both satisfy R6 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; `smp_data` is taken when high |
| smp_data | input | DW | Unsigned sample from the converter |
| avg_valid | output | 1 | One-cycle pulse marking a new average |
| avg_out | output | DW | Window average, held between pulses |

## Verification
Four properties are checked on every cycle: the total stays below its ceiling, no pulse appears before the window is full, two pulses are always exactly `DEC` accepted samples apart, and idle cycles leave the total and `avg_out` untouched. Only the bench's scenarios can show that the arithmetic is exact. Those scenarios cover a constant level, full-scale samples, a pseudo-random sequence, and gaps carrying junk data. They run against both a reciprocal-multiply instance and a shift instance, and the pulse timing is compared against an independent sample-count model.

// File: rtl/mains_boxcar.sv
module mains_boxcar #(
  parameter int DW  = 12,
  parameter int WIN = 60,
  parameter int DEC = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          avg_valid,
  output logic [DW-1:0] avg_out
);
  localparam int LW    = $clog2(WIN);
  localparam int SUMW  = DW + LW;
  localparam int AW    = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int FW    = $clog2(WIN + 1);
  localparam int CW    = (DEC > 1) ? $clog2(DEC) : 1;
  localparam int SH    = SUMW + LW + 1;
  localparam int PW    = SUMW + SH + 1;
  localparam bit POW2  = (WIN == (1 << LW));
  localparam logic [SUMW:0] SUM_MAX = (SUMW+1)'(WIN * ((1 << DW) - 1));

  logic [DW-1:0]   mem [WIN];
  logic [AW-1:0]   wp;
  logic [FW-1:0]   fill;
  logic [CW-1:0]   dcnt;
  logic [SUMW-1:0] sum;
  logic [SUMW-1:0] sum_nxt;
  logic [DW-1:0]   leaving;
  logic [DW-1:0]   avg_nxt;
  logic            full, full_nxt, fire;

  assign full     = (fill == FW'(WIN));
  assign full_nxt = full || (fill == FW'(WIN - 1));
  assign leaving  = full ? mem[wp] : '0;
  assign sum_nxt  = sum + SUMW'(smp_data) - SUMW'(leaving);
  assign fire     = smp_valid && full_nxt && (dcnt == CW'(DEC - 1));

  generate
    if (POW2) begin : g_shift
      assign avg_nxt = DW'(sum_nxt >> LW);
    end else begin : g_recip
      localparam logic [SH:0] RECIP = (SH+1)'(((64'd1 << SH) + 64'(WIN) - 64'd1) / 64'(WIN));
      logic [PW-1:0] prod;
      assign prod    = PW'(sum_nxt) * PW'(RECIP);
      assign avg_nxt = DW'(prod >> SH);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (smp_valid) mem[wp] <= smp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      fill      <= '0;
      dcnt      <= '0;
      sum       <= '0;
      avg_valid <= 1'b0;
      avg_out   <= '0;
    end else begin
      avg_valid <= fire;
      if (fire) avg_out <= avg_nxt;
      if (smp_valid) begin
        sum  <= sum_nxt;
        wp   <= (wp == AW'(WIN - 1)) ? '0 : wp + 1'b1;
        dcnt <= (dcnt == CW'(DEC - 1)) ? '0 : dcnt + 1'b1;
        if (!full) fill <= fill + 1'b1;
      end
    end
  end

  int unsigned since;
  logic        seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= 0;
      seen  <= 1'b0;
    end else if (avg_valid) begin
      since <= smp_valid ? 1 : 0;
      seen  <= 1'b1;
    end else begin
      since <= since + (smp_valid ? 1 : 0);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, sum} <= SUM_MAX);
  a_r2_no_early_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> full);
  a_r5_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_valid && seen) |-> (since == DEC));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_valid && (DEC > 1)) |=> !avg_valid);
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(sum));
  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_valid |-> $stable(avg_out));
endmodule

// File: tb/tb_mains_boxcar.sv
module tb_mains_boxcar;
  localparam int DW = 12;
  localparam int W1 = 60, D1 = 100;
  localparam int W2 = 16, D2 = 10;

  logic clk = 0, rst_n = 0, smp_valid = 0;
  logic [DW-1:0] smp_data = '0;
  logic v1, v2;
  logic [DW-1:0] o1, o2;

  always #2 clk = ~clk;

  mains_boxcar #(.DW(DW), .WIN(W1), .DEC(D1)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .avg_valid(v1), .avg_out(o1));
  mains_boxcar #(.DW(DW), .WIN(W2), .DEC(D2)) dut_p2 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .avg_valid(v2), .avg_out(o2));

  int tests = 0, fails = 0, n = 0;
  int hist [8192];
  int q1[$], q2[$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic int win_avg(int w);
    int s = 0;
    for (int i = n - w; i < n; i++) s += hist[i];
    return s / w;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (sample %0d)", req, act, exp, n);
    end
  endtask

  task automatic send(int d);
    bit e1, e2;
    @(negedge clk);
    smp_valid = 1; smp_data = DW'(d);
    hist[n] = d; n++;
    e1 = (n >= W1) && (n % D1 == 0);
    e2 = (n >= W2) && (n % D2 == 0);
    if (e1) q1.push_back(win_avg(W1));
    if (e2) q2.push_back(win_avg(W2));
    @(posedge clk); #1;
    chk((n < W1) ? "R2 pulse (recip)" : "R5 pulse (recip)", int'(v1), int'(e1));
    chk((n < W2) ? "R2 pulse (shift)" : "R5 pulse (shift)", int'(v2), int'(e2));
  endtask

  task automatic idle(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      smp_valid = 0; smp_data = DW'(12'hA5A + i * 37);
      @(posedge clk); #1;
      chk("R7 no pulse on idle", int'(v1 | v2), 0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && v1) begin
      if (q1.size() == 0) chk("R5 unexpected pulse (recip)", 1, 0);
      else chk("R6/R9 average (recip)", int'(o1), q1.pop_front());
    end
    if (rst_n && v2) begin
      if (q2.size() == 0) chk("R5 unexpected pulse (shift)", 1, 0);
      else chk("R6/R9 average (shift)", int'(o2), q2.pop_front());
    end
  end

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset valid", int'(v1 | v2), 0);
    chk("R1 reset data", int'(o1 | o2), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 after reset valid", int'(v1 | v2), 0);
    chk("R1 after reset data", int'(o1 | o2), 0);

    for (int i = 0; i < 300; i++) send(1000);           // R4 constant level
    chk("R4 constant exact (recip)", int'(o1), 1000);
    chk("R4 constant exact (shift)", int'(o2), 1000);
    for (int i = 0; i < 300; i++) send(4095);           // R3 full scale
    chk("R3 full-scale no overflow (recip)", int'(o1), 4095);
    chk("R3 full-scale no overflow (shift)", int'(o2), 4095);
    for (int i = 0; i < 1200; i++) begin                 // R6 random
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'(lfsr[11:0]));
    end
    for (int k = 0; k < 40; k++) begin                   // R7 gaps with junk
      held = int'(o1);
      idle(3);
      chk("R8 output held across idle", int'(o1), held);
      for (int i = 0; i < 7; i++) send((k * 97 + i * 13) % 4096);
    end
    for (int i = 0; i < 200; i++) send(7);
    chk("R4 small constant (recip)", int'(o1), 7);
    idle(2);
    chk("R5 all expected pulses seen (recip)", q1.size(), 0);
    chk("R5 all expected pulses seen (shift)", q2.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule